// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent 32-bit timers that count down on the system clock. Each timer sits in its own window of a flat register space. A window has a reload register, a live count register and a control register. To start a timer, software writes the tick count to the reload register and to the live count register, and then writes the control register with the run bit set. In periodic mode the timer reloads itself from the reload register whenever it reaches zero. With a reload value of all ones this makes a free-running 32-bit counter that wraps, and the bitwise inverse of its count rises with time. In one-shot mode the timer stops at zero. In either mode it can latch a pending interrupt.

Timers 0, 1 and 2 each drive one interrupt line. Timer 3 has no line and is polled. A pending interrupt is removed by writing the control register with the acknowledge bit set. The usual driver sequence is a read-modify-write that sets bit 3, followed by a read-modify-write that clears bit 2. Register reads are combinational from the word address. A write is taken on a rising clock edge when both the valid strobe and the write strobe are high.

Top module: `qtmr_top`

## Requirements
- R1: After a synchronous reset, every reload, count and control register of every timer reads zero and all interrupt lines are low.
- R2: `bus_addr` is a word address. Timer i uses word 4*i+0 for the reload register, 4*i+1 for the live count and 4*i+2 for control. Word 4*i+3 reads zero. A write to one timer's window changes no other timer.
- R3: The control word bits are: bit 0 run, bit 1 periodic reload, bit 2 interrupt enable, bit 3 acknowledge (write-only, reads 0), bit 4 pending (read-only). Bits 31:5 read zero.
- R4: While run is set, the live count drops by exactly one on each clock edge. No count step happens on an edge that writes the control register.
- R5: When the count is zero and periodic reload is on, the next edge loads the count from the reload register, so the period is reload+1 edges. A reload of all ones therefore wraps from 0 to 0xFFFFFFFF.
- R6: When the count is zero and periodic reload is off, the next edge clears run and the count stays at zero.
- R7: The edge that processes a zero count sets pending only if interrupt enable is 1.
- R8: Interrupt line i (i = 0..2) is high exactly when timer i has both pending and interrupt enable set. Timer 3 drives no line.
- R9: A control write with bit 3 set clears pending. The two-step sequence (write control|0x08, then write control&0x1FB) leaves the control register at zero and the line low.
- R10: A write to the live count on the same edge as a count step stores the written value unchanged.
- R11: Writing zero to control freezes the live count and drops the timer's interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe; qualifies writes |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | ADDR_W (4) | Word address: timer index in the upper bits, register in bits 1:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | N_IRQ (3) | Interrupt line per timer 0..N_IRQ-1 |

## Verification
The bench checks the zero count from several directions. A periodic timer must reappear at its reload value one edge after zero. A design with an off-by-one period would show a count of zero or reload-1 at that sample. The one-shot case must hold at zero with run cleared and pending raised. A design that kept counting would wrap to all ones. The free-running timer is followed across the wrap and its inverse is read a fixed number of cycles later. A live-count write is made into a running timer, where a design that let the decrement win would read back one less. The acknowledge sequence is checked after each step. A timer without an interrupt line must not disturb the others' lines or windows.

// File: rtl/qtmr_pkg.sv
// Package: shared register indices, control bit positions and the
// per-timer control state type for the four-channel down-counter.
package qtmr_pkg;
    localparam int REG_LOAD  = 0;
    localparam int REG_VALUE = 1;
    localparam int REG_CTRL  = 2;

    localparam int CB_EN   = 0;
    localparam int CB_RLD  = 1;
    localparam int CB_IE   = 2;
    localparam int CB_ACK  = 3;
    localparam int CB_PEND = 4;
    localparam int CB_USED = 5;

    typedef struct packed {
        logic pend;
        logic ie;
        logic rld;
        logic en;
    } tmr_ctl_t;
endpackage

// File: rtl/qtmr_decode.sv
// Module: write decoder. Splits the word address into timer index and
// register index and raises one write enable per timer and register.
// Assumes N_TMR is a power of two of at least 2 and AW = log2(N_TMR)+2.
module qtmr_decode
    import qtmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int AW    = 4
) (
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [AW-1:0]             bus_addr,
    output logic [N_TMR-1:0]          ld_we,
    output logic [N_TMR-1:0]          val_we,
    output logic [N_TMR-1:0]          ctl_we,
    output logic [$clog2(N_TMR)-1:0]  sel_idx,
    output logic [1:0]                sel_reg
);
    localparam int IDX_W = $clog2(N_TMR);

    logic wr;

    // Address split and write qualification.
    always_comb begin
        sel_idx = bus_addr[AW-1:2];
        sel_reg = bus_addr[1:0];
        wr      = bus_valid && bus_write;
    end

    // One enable per timer and register.
    for (genvar i = 0; i < N_TMR; i++) begin : g_we
        assign ld_we[i]  = wr && (sel_idx == IDX_W'(i)) && (sel_reg == 2'(REG_LOAD));
        assign val_we[i] = wr && (sel_idx == IDX_W'(i)) && (sel_reg == 2'(REG_VALUE));
        assign ctl_we[i] = wr && (sel_idx == IDX_W'(i)) && (sel_reg == 2'(REG_CTRL));
    end
endmodule

// File: rtl/qtmr_channel.sv
// Module: one down-counting timer. Holds the reload, the live count and the
// control state. Assumes at most one of its write enables is high per cycle.
// A control write suppresses the count step and zero handling on its edge.
module qtmr_channel
    import qtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          val_we,
    input  logic          ctl_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] load_q,
    output logic [DW-1:0] value_q,
    output tmr_ctl_t      ctl_q
);
    logic active;
    logic at_zero;
    logic hit;
    logic step;

    // Classify this cycle: counting step, zero handling, or idle.
    always_comb begin
        active  = ctl_q.en && !ctl_we;
        at_zero = (value_q == '0);
        hit     = active && at_zero;
        step    = active && !at_zero;
    end

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)     load_q <= '0;
        else if (ld_we) load_q <= wdata;
    end

    // Live count: a software write wins over the step and the reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                value_q <= '0;
        else if (val_we)           value_q <= wdata;
        else if (step)             value_q <= value_q - 1'b1;
        else if (hit && ctl_q.rld) value_q <= load_q;
    end

    // Control state: software write, or one-shot stop and pending set at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q.en  <= wdata[CB_EN];
            ctl_q.rld <= wdata[CB_RLD];
            ctl_q.ie  <= wdata[CB_IE];
            if (wdata[CB_ACK]) ctl_q.pend <= 1'b0;
        end else if (hit) begin
            if (!ctl_q.rld) ctl_q.en   <= 1'b0;
            if (ctl_q.ie)   ctl_q.pend <= 1'b1;
        end
    end
endmodule

// File: rtl/qtmr_rdmux.sv
// Module: read multiplexer. Returns the addressed register of the selected
// timer; the control word carries the state bits and zeros elsewhere.
module qtmr_rdmux
    import qtmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int DW    = 32
) (
    input  logic [N_TMR-1:0][DW-1:0]  load_arr,
    input  logic [N_TMR-1:0][DW-1:0]  value_arr,
    input  tmr_ctl_t [N_TMR-1:0]      ctl_arr,
    input  logic [$clog2(N_TMR)-1:0]  sel_idx,
    input  logic [1:0]                sel_reg,
    output logic [DW-1:0]             rdata
);
    tmr_ctl_t c;

    // Register select for the addressed word.
    always_comb begin
        c     = ctl_arr[sel_idx];
        rdata = '0;
        case (sel_reg)
            2'(REG_LOAD):  rdata = load_arr[sel_idx];
            2'(REG_VALUE): rdata = value_arr[sel_idx];
            2'(REG_CTRL): begin
                rdata[CB_EN]   = c.en;
                rdata[CB_RLD]  = c.rld;
                rdata[CB_IE]   = c.ie;
                rdata[CB_PEND] = c.pend;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/qtmr_top.sv
// Module: four-channel down-counting timer. Decodes a flat word-addressed
// register space into N_TMR timer windows and drives one interrupt line
// for each of the first N_IRQ timers. Assumes N_IRQ <= N_TMR.
module qtmr_top
    import qtmr_pkg::*;
#(
    parameter int N_TMR  = 4,
    parameter int N_IRQ  = 3,
    parameter int DW     = 32,
    parameter int ADDR_W = $clog2(N_TMR) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_IRQ-1:0]  irq
);
    localparam int IDX_W = $clog2(N_TMR);

    logic [N_TMR-1:0]          ld_we, val_we, ctl_we;
    logic [IDX_W-1:0]          sel_idx;
    logic [1:0]                sel_reg;
    logic [N_TMR-1:0][DW-1:0]  load_arr, value_arr;
    tmr_ctl_t [N_TMR-1:0]      ctl_arr;
    logic [N_TMR-1:0]          en_v, rld_v, ie_v, pend_v;

    qtmr_decode #(.N_TMR(N_TMR), .AW(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .ld_we     (ld_we),
        .val_we    (val_we),
        .ctl_we    (ctl_we),
        .sel_idx   (sel_idx),
        .sel_reg   (sel_reg)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        qtmr_channel #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_we   (ld_we[i]),
            .val_we  (val_we[i]),
            .ctl_we  (ctl_we[i]),
            .wdata   (bus_wdata),
            .load_q  (load_arr[i]),
            .value_q (value_arr[i]),
            .ctl_q   (ctl_arr[i])
        );
        assign en_v[i]   = ctl_arr[i].en;
        assign rld_v[i]  = ctl_arr[i].rld;
        assign ie_v[i]   = ctl_arr[i].ie;
        assign pend_v[i] = ctl_arr[i].pend;
    end

    // Interrupt lines only for the first N_IRQ timers.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq[i] = pend_v[i] && ie_v[i];
    end

    qtmr_rdmux #(.N_TMR(N_TMR), .DW(DW)) u_rd (
        .load_arr  (load_arr),
        .value_arr (value_arr),
        .ctl_arr   (ctl_arr),
        .sel_idx   (sel_idx),
        .sel_reg   (sel_reg),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/qtmr_checker.sv
// Module: assertion checker for qtmr_top, attached by bind below. Watches
// the per-timer write enables and register state over time.
module qtmr_checker
    import qtmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int N_IRQ = 3,
    parameter int DW    = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_TMR-1:0]         ld_we,
    input logic [N_TMR-1:0]         val_we,
    input logic [N_TMR-1:0]         ctl_we,
    input logic [DW-1:0]            wdata,
    input logic [N_TMR-1:0][DW-1:0] load_arr,
    input logic [N_TMR-1:0][DW-1:0] value_arr,
    input logic [N_TMR-1:0]         en_v,
    input logic [N_TMR-1:0]         rld_v,
    input logic [N_TMR-1:0]         ie_v,
    input logic [N_TMR-1:0]         pend_v,
    input logic [N_IRQ-1:0]         irq
);
    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            ld_we[i] |=> load_arr[i] == $past(wdata)); // R2
        AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[i] && value_arr[i] != '0 && !ctl_we[i] && !val_we[i])
            |=> value_arr[i] == $past(value_arr[i]) - 1'b1); // R4
        AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[i] && rld_v[i] && value_arr[i] == '0 && !ctl_we[i] && !val_we[i])
            |=> value_arr[i] == $past(load_arr[i])); // R5
        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[i] && !rld_v[i] && value_arr[i] == '0 && !ctl_we[i] && !val_we[i])
            |=> !en_v[i] && value_arr[i] == '0); // R6
        AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_v[i]) |-> $past(ie_v[i])); // R7
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_we[i] && wdata[CB_ACK]) |=> !pend_v[i]); // R9
        AST_VALUE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            val_we[i] |=> value_arr[i] == $past(wdata)); // R10
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[i] && !val_we[i]) |=> $stable(value_arr[i])); // R11
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq_chk
        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |->
                $past(ie_v[i] && en_v[i] && value_arr[i] == '0 && !ctl_we[i]) ||
                $past(ctl_we[i] && wdata[CB_IE])); // R8
    end
endmodule

bind qtmr_top qtmr_checker #(.N_TMR(N_TMR), .N_IRQ(N_IRQ), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_we     (ld_we),
    .val_we    (val_we),
    .ctl_we    (ctl_we),
    .wdata     (bus_wdata),
    .load_arr  (load_arr),
    .value_arr (value_arr),
    .en_v      (en_v),
    .rld_v     (rld_v),
    .ie_v      (ie_v),
    .pend_v    (pend_v),
    .irq       (irq)
);

// File: tb/qtmr_top_tb.sv
`timescale 1ns/100ps
// Bench: scoreboard for qtmr_top. Driver tasks push expected read or irq
// values into a queue; a monitor pops each one and compares it with the port.
module qtmr_top_tb;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    typedef struct {
        int          kind;   // 0 = read data, 1 = irq vector
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    qtmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: compare each queued expectation against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #0.5;
            if (q.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = (it.kind == 1) ? {29'b0, irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic logic [AW-1:0] ad(input int t, input int r);
        return AW'(t * 4 + r);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        exp_t it;
        it.kind = 1; it.exp = {29'b0, e}; it.tag = tag;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: stimulus with expected values worked out from the requirements.
    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        rd(ad(0,0), 32'h0, "R1 load0");
        rd(ad(0,1), 32'h0, "R1 value0");
        rd(ad(1,2), 32'h0, "R1 ctrl1");
        chk_irq(3'b000, "R1 irq");
        tick(1);
        rd(ad(2,2), 32'h0, "R1 ctrl2");
        rd(ad(3,1), 32'h0, "R1 value3");

        // R6 R7 R8 R9: one-shot with interrupt on timer 2
        wr(ad(2,0), 32'd5);
        rd(ad(2,0), 32'd5, "R2 load2 readback");
        wr(ad(2,1), 32'd5);
        wr(ad(2,2), 32'h05);
        rd(ad(2,1), 32'd5, "R4 no step on control edge");
        tick(5);
        rd(ad(2,1), 32'd0, "R4 counted to zero");
        chk_irq(3'b000, "R7 not pending before zero edge");
        tick(1);
        rd(ad(2,2), 32'h14, "R6 R7 run cleared pending set");
        chk_irq(3'b100, "R8 irq2 high");
        tick(3);
        rd(ad(2,1), 32'd0, "R6 holds zero");
        wr(ad(2,2), 32'h1C);
        rd(ad(2,2), 32'h04, "R9 ack clears pending");
        chk_irq(3'b000, "R9 irq2 low after ack");
        wr(ad(2,2), 32'h18);
        rd(ad(2,2), 32'h00, "R9 ctrl zero after sequence");

        // R5: periodic reload, no interrupt enable
        wr(ad(0,0), 32'd3);
        wr(ad(0,1), 32'd3);
        wr(ad(0,2), 32'h03);
        tick(3);
        rd(ad(0,1), 32'd0, "R4 timer0 at zero");
        tick(1);
        rd(ad(0,1), 32'd3, "R5 reload after zero");
        tick(1);
        rd(ad(0,1), 32'd2, "R5 counting after reload");
        rd(ad(0,2), 32'h03, "R7 no pending without enable");
        chk_irq(3'b000, "R7 irq0 low");

        // R10: write into a running timer
        wr(ad(0,1), 32'd100);
        rd(ad(0,1), 32'd100, "R10 write beats decrement");
        tick(1);
        rd(ad(0,1), 32'd99, "R4 step after write");
        wr(ad(0,2), 32'h0);

        // R8: periodic with interrupt on timer 0
        wr(ad(0,0), 32'd2);
        wr(ad(0,1), 32'd2);
        wr(ad(0,2), 32'h07);
        tick(2);
        rd(ad(0,1), 32'd0, "R4 timer0 zero again");
        chk_irq(3'b000, "R8 irq0 low before zero edge");
        tick(1);
        rd(ad(0,1), 32'd2, "R5 reload with interrupt");
        rd(ad(0,2), 32'h17, "R7 pending in periodic");
        chk_irq(3'b001, "R8 irq0 high");
        wr(ad(0,2), 32'h0F);
        chk_irq(3'b000, "R9 ack keeps running");
        rd(ad(0,2), 32'h07, "R3 ack bit reads zero");
        wr(ad(0,2), 32'h0);

        // R5 R4: free-running wrap on timer 1
        wr(ad(1,0), 32'hFFFF_FFFF);
        wr(ad(1,1), 32'd1);
        wr(ad(1,2), 32'h03);
        tick(1);
        rd(ad(1,1), 32'd0, "R4 timer1 zero");
        tick(1);
        rd(ad(1,1), 32'hFFFF_FFFF, "R5 wrap to all ones");
        tick(10);
        rd(ad(1,1), 32'hFFFF_FFF5, "R4 inverse rises by ten");
        // R11: writing zero freezes
        wr(ad(1,2), 32'h0);
        rd(ad(1,1), 32'hFFFF_FFF5, "R11 frozen at stop edge");
        tick(5);
        rd(ad(1,1), 32'hFFFF_FFF5, "R11 still frozen");

        // R8 R2: timer 3 has no line; windows are independent
        wr(ad(3,1), 32'd1);
        wr(ad(3,2), 32'h05);
        tick(2);
        rd(ad(3,2), 32'h14, "R8 timer3 pending");
        chk_irq(3'b000, "R8 timer3 drives no line");
        rd(ad(2,1), 32'd0, "R2 timer2 untouched");
        rd(ad(3,3), 32'h0, "R2 spare word reads zero");
        tick(1);
        rd(ad(0,3), 32'h0, "R2 spare word timer0");

        // R11: zero control drops a live line
        wr(ad(1,1), 32'd0);
        wr(ad(1,2), 32'h05);
        tick(1);
        chk_irq(3'b010, "R8 irq1 high");
        wr(ad(1,2), 32'h0);
        chk_irq(3'b000, "R11 line drops on zero control");

        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule